// File: doc/BRIEF.md
# Fractional SCL Rate Divider

This block produces the half-period step pulses that a two-wire bus engine uses to advance its SCL phases. It runs from the 100 MHz module clock and does not count whole clock periods. Instead it keeps a fractional accumulator. On every enabled step it adds a programmable increment. When the sum reaches the modulus (the decrement field plus one), it subtracts the modulus and emits a one-cycle tick. The tick rate is therefore f_step × INC / (DEC + 1). The bus engine takes two ticks for each SCL period, so the pair (1, 499) yields 200 kHz ticks for a 100 kHz bus and the pair (1, 124) yields 800 kHz ticks for a 400 kHz bus.

Two rate registers exist: one for standard and fast operation, and one for high-speed operation. Software normally zeroes the one it does not use. The block picks between them by content. A register whose increment is zero counts as inactive, and the high-speed register wins when both are active. A small module-clock prescaler sits in front of the accumulator and sets how many module clocks pass per accumulator step. It comes out of reset at 1, so there is one step per clock. Any configuration write restarts the accumulator and the prescaler from zero, so a new rate always starts from a clean phase.

Top module: `scl_frac_div`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) both rate registers read zero, the prescale divider is 1 and `tick` is low; no tick appears until a rate register is written.
- R2: On each accumulator step with an active increment I and decrement field D where I <= D, the accumulator adds I; if the sum is at least D+1 it subtracts D+1 and `tick` is high for the one cycle following that edge, otherwise `tick` is low. From a cleared accumulator, N steps yield floor(N×I/(D+1)) ticks.
- R3: The high-speed register is used whenever its increment is nonzero; otherwise the normal register is used if its increment is nonzero.
- R4: When both registers hold a zero increment, no tick is produced and the accumulator holds.
- R5: A write to either rate register or to the prescale divider clears the accumulator and the prescale count, and `tick` is low in the cycle after the write edge.
- R6: With prescale divider P > 0 an accumulator step occurs once every P module clocks, the first on the P-th edge after a write; with P = 0 no step occurs and the accumulator holds.
- R7: If the active increment exceeds the decrement field (I >= D+1), every step produces a tick and the accumulator stays at zero.
- R8: With one step per clock, (1, 499) gives 2 ticks in 1000 clocks, (1, 124) gives 10 ticks in 1250 clocks, and (41, 152) gives 410 ticks in 1530 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock (100 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| norm_wr | input | 1 | Load `wr_inc`/`wr_dec` into the normal-rate register |
| hs_wr | input | 1 | Load `wr_inc`/`wr_dec` into the high-speed rate register |
| wr_inc | input | INC_W | Increment value to write |
| wr_dec | input | DEC_W | Decrement value to write (modulus minus one) |
| div_wr | input | 1 | Load `wr_div` into the prescale divider |
| wr_div | input | PRE_W | Module clocks per accumulator step; 0 halts |
| tick | output | 1 | One-cycle SCL half-period step pulse |

## Verification
The bench builds the block with its default widths: an 8-bit increment, a 10-bit decrement and a 4-bit prescaler. These are wide enough to hold the standard, fast and high-speed settings exactly, so the three real tick rates can be counted over windows of a few thousand clocks. The same widths also reach the case where the increment exceeds the modulus, and prescale values of 0 and 3, which cover the halt and the phase of the first step. A behavioural model kept in integers predicts `tick` on every clock, and windowed tick counts check the long-run rates, the register priority and the restart on write.

// File: rtl/scl_div_pkg.sv
// Shared types for the fractional SCL rate divider.
package scl_div_pkg;

    // Which rate register currently drives the accumulator.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NORM = 2'd1,
        SRC_HS   = 2'd2
    } rate_src_e;

    // Index of each bank inside the configuration register array.
    localparam int BANK_NORM = 0;
    localparam int BANK_HS   = 1;
    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/scl_div_cfg_regs.sv
// Configuration storage for the divider.
// Holds the normal and high-speed increment/decrement pairs and the
// prescale divider. Any write produces a restart pulse in the same cycle
// so that downstream state restarts on the write edge.
// Assumes: writes are single-cycle strobes from a register interface.
module scl_div_cfg_regs #(
    parameter int INC_W   = 8,
    parameter int DEC_W   = 10,
    parameter int PRE_W   = 4,
    parameter int DIV_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             norm_wr,
    input  logic             hs_wr,
    input  logic [INC_W-1:0] wr_inc,
    input  logic [DEC_W-1:0] wr_dec,
    input  logic             div_wr,
    input  logic [PRE_W-1:0] wr_div,
    output logic [INC_W-1:0] norm_inc,
    output logic [DEC_W-1:0] norm_dec,
    output logic [INC_W-1:0] hs_inc,
    output logic [DEC_W-1:0] hs_dec,
    output logic [PRE_W-1:0] div_q,
    output logic             restart
);
    import scl_div_pkg::*;

    logic [NUM_BANKS-1:0] bank_wr;
    logic [INC_W-1:0]     inc_q [NUM_BANKS];
    logic [DEC_W-1:0]     dec_q [NUM_BANKS];

    // Route each write strobe to its bank.
    always_comb begin
        bank_wr            = '0;
        bank_wr[BANK_NORM] = norm_wr;
        bank_wr[BANK_HS]   = hs_wr;
    end

    // One storage bank per rate register.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Load the increment/decrement pair of this bank on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inc_q[b] <= '0;
                dec_q[b] <= '0;
            end else if (bank_wr[b]) begin
                inc_q[b] <= wr_inc;
                dec_q[b] <= wr_dec;
            end
        end
    end

    // Hold the prescale divider, reset to one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= PRE_W'(DIV_RST);
        end else if (div_wr) begin
            div_q <= wr_div;
        end
    end

    // Expose the banks and flag any write as a restart.
    always_comb begin
        norm_inc = inc_q[BANK_NORM];
        norm_dec = dec_q[BANK_NORM];
        hs_inc   = inc_q[BANK_HS];
        hs_dec   = dec_q[BANK_HS];
        restart  = norm_wr | hs_wr | div_wr;
    end

endmodule

// File: rtl/scl_div_select.sv
// Rate register selection.
// Picks the high-speed pair when its increment is nonzero, else the
// normal pair when its increment is nonzero, else nothing (outputs zero).
// Assumes: a zero increment marks a register as unused.
module scl_div_select #(
    parameter int INC_W = 8,
    parameter int DEC_W = 10
) (
    input  logic [INC_W-1:0]            norm_inc,
    input  logic [DEC_W-1:0]            norm_dec,
    input  logic [INC_W-1:0]            hs_inc,
    input  logic [DEC_W-1:0]            hs_dec,
    output scl_div_pkg::rate_src_e      src,
    output logic [INC_W-1:0]            act_inc,
    output logic [DEC_W-1:0]            act_dec
);
    import scl_div_pkg::*;

    // Priority pick by register content.
    always_comb begin
        if (hs_inc != '0) begin
            src     = SRC_HS;
            act_inc = hs_inc;
            act_dec = hs_dec;
        end else if (norm_inc != '0) begin
            src     = SRC_NORM;
            act_inc = norm_inc;
            act_dec = norm_dec;
        end else begin
            src     = SRC_NONE;
            act_inc = '0;
            act_dec = '0;
        end
    end

endmodule

// File: rtl/scl_div_prescale.sv
// Module-clock prescaler.
// Emits a step enable once every div module clocks; div = 0 halts.
// A restart clears the count so the first step lands div clocks later.
// Assumes: div changes only together with a restart.
module scl_div_prescale #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div,
    input  logic             restart,
    output logic             step_en
);
    logic [PRE_W-1:0] cnt_q;
    logic             at_end;

    // Last count of the period, only meaningful for a nonzero divider.
    always_comb begin
        at_end  = (div != '0) && (cnt_q == div - PRE_W'(1));
        step_en = at_end && !restart;
    end

    // Advance the period counter, wrapping at the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || div == '0 || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/scl_div_accum.sv
// Fractional accumulator and tick generator.
// On each step adds the increment; when the sum reaches dec+1 it wraps by
// dec+1 and registers a one-cycle tick. An increment above dec ticks on
// every step with the accumulator held at zero.
// Assumes: INC_W <= DEC_W + 1.
module scl_div_accum #(
    parameter int INC_W = 8,
    parameter int DEC_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        restart,
    input  logic                        step_en,
    input  scl_div_pkg::rate_src_e      src,
    input  logic [INC_W-1:0]            act_inc,
    input  logic [DEC_W-1:0]            act_dec,
    output logic [DEC_W:0]              acc,
    output logic                        tick
);
    import scl_div_pkg::*;

    localparam int MOD_W = DEC_W + 1;
    localparam int SUM_W = MOD_W + 1;

    logic [MOD_W-1:0] acc_q;
    logic [SUM_W-1:0] modulus;
    logic [SUM_W-1:0] inc_ext;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;
    logic             too_wide;
    logic             overflow;
    logic             tick_q;

    // Datapath: sum, modulus and wrap decision.
    always_comb begin
        modulus  = SUM_W'(act_dec) + SUM_W'(1);
        inc_ext  = SUM_W'(act_inc);
        sum      = SUM_W'(acc_q) + inc_ext;
        wrapped  = sum - modulus;
        too_wide = inc_ext >= modulus;
        overflow = sum >= modulus;
    end

    // Accumulator state and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (restart) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (step_en && src != SRC_NONE) begin
            if (too_wide) begin
                acc_q  <= '0;
                tick_q <= 1'b1;
            end else if (overflow) begin
                acc_q  <= MOD_W'(wrapped);
                tick_q <= 1'b1;
            end else begin
                acc_q  <= MOD_W'(sum);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    // Drive outputs from state.
    always_comb begin
        acc  = acc_q;
        tick = tick_q;
    end

endmodule

// File: rtl/scl_frac_div.sv
// Fractional SCL rate divider, top level.
// Ties configuration storage, register selection, prescaler and
// accumulator together and presents a single-cycle half-period tick.
// Assumes: one module clock domain, synchronous active-low reset.
module scl_frac_div #(
    parameter int INC_W   = 8,
    parameter int DEC_W   = 10,
    parameter int PRE_W   = 4,
    parameter int DIV_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             norm_wr,
    input  logic             hs_wr,
    input  logic [INC_W-1:0] wr_inc,
    input  logic [DEC_W-1:0] wr_dec,
    input  logic             div_wr,
    input  logic [PRE_W-1:0] wr_div,
    output logic             tick
);
    import scl_div_pkg::*;

    logic [INC_W-1:0] norm_inc;
    logic [DEC_W-1:0] norm_dec;
    logic [INC_W-1:0] hs_inc;
    logic [DEC_W-1:0] hs_dec;
    logic [PRE_W-1:0] div_q;
    logic             restart;
    logic             step_en;
    rate_src_e        src;
    logic [INC_W-1:0] act_inc;
    logic [DEC_W-1:0] act_dec;
    logic [DEC_W:0]   acc_lvl;

    scl_div_cfg_regs #(
        .INC_W   (INC_W),
        .DEC_W   (DEC_W),
        .PRE_W   (PRE_W),
        .DIV_RST (DIV_RST)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .norm_wr  (norm_wr),
        .hs_wr    (hs_wr),
        .wr_inc   (wr_inc),
        .wr_dec   (wr_dec),
        .div_wr   (div_wr),
        .wr_div   (wr_div),
        .norm_inc (norm_inc),
        .norm_dec (norm_dec),
        .hs_inc   (hs_inc),
        .hs_dec   (hs_dec),
        .div_q    (div_q),
        .restart  (restart)
    );

    scl_div_select #(
        .INC_W (INC_W),
        .DEC_W (DEC_W)
    ) i_sel (
        .norm_inc (norm_inc),
        .norm_dec (norm_dec),
        .hs_inc   (hs_inc),
        .hs_dec   (hs_dec),
        .src      (src),
        .act_inc  (act_inc),
        .act_dec  (act_dec)
    );

    scl_div_prescale #(
        .PRE_W (PRE_W)
    ) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_q),
        .restart (restart),
        .step_en (step_en)
    );

    scl_div_accum #(
        .INC_W (INC_W),
        .DEC_W (DEC_W)
    ) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step_en (step_en),
        .src     (src),
        .act_inc (act_inc),
        .act_dec (act_dec),
        .acc     (acc_lvl),
        .tick    (tick)
    );

endmodule

// File: rtl/scl_div_checker.sv
// Property checker for the fractional SCL rate divider, bound to the top.
// Assumes: observes only top-level ports and inter-module nets.
module scl_div_checker #(
    parameter int INC_W = 8,
    parameter int DEC_W = 10,
    parameter int PRE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             restart,
    input logic             step_en,
    input logic [INC_W-1:0] act_inc,
    input logic [DEC_W-1:0] act_dec,
    input logic [PRE_W-1:0] div_q,
    input logic [DEC_W:0]   acc_lvl
);
    // R1: a reset edge leaves the tick low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !tick);

    // R5: a configuration write clears the accumulator and the tick.
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tick && acc_lvl == '0));

    // R2: a tick only follows a prescaler step.
    a_r2_tick_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !tick);

    // R2: after a step the accumulator sits below the modulus.
    a_r2_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && act_inc != '0) |=> (acc_lvl <= (DEC_W+1)'($past(act_dec))));

    // R4: with no active register the accumulator holds and no tick appears.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (act_inc == '0 && !restart) |=> (!tick && $stable(acc_lvl)));

    // R6: a zero divider halts the accumulator.
    a_r6_zero_div_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && !restart) |=> (!tick && $stable(acc_lvl)));

    // R7: an increment above the decrement ticks every step at zero level.
    a_r7_wide_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && act_inc != '0 && (DEC_W+1)'(act_inc) > (DEC_W+1)'(act_dec))
        |=> (tick && acc_lvl == '0));

endmodule

bind scl_frac_div scl_div_checker #(
    .INC_W (INC_W),
    .DEC_W (DEC_W),
    .PRE_W (PRE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .step_en (step_en),
    .act_inc (act_inc),
    .act_dec (act_dec),
    .div_q   (div_q),
    .acc_lvl (acc_lvl)
);

// File: tb/test_scl_frac_div.sv
// Bench: integer reference model compared on every clock plus windowed counts.
module test_scl_frac_div;
    localparam int INC_W = 8;
    localparam int DEC_W = 10;
    localparam int PRE_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             norm_wr;
    logic             hs_wr;
    logic [INC_W-1:0] wr_inc;
    logic [DEC_W-1:0] wr_dec;
    logic             div_wr;
    logic [PRE_W-1:0] wr_div;
    logic             tick;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Reference model state.
    int m_ninc, m_ndec, m_hinc, m_hdec, m_div, m_acc, m_pc;
    bit exp_tick = 0;

    always #10 clk = ~clk;

    scl_frac_div #(
        .INC_W (INC_W),
        .DEC_W (DEC_W),
        .PRE_W (PRE_W)
    ) i_scl_frac_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .norm_wr (norm_wr),
        .hs_wr   (hs_wr),
        .wr_inc  (wr_inc),
        .wr_dec  (wr_dec),
        .div_wr  (div_wr),
        .wr_div  (wr_div),
        .tick    (tick)
    );

    // Behavioural model of the requirements, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ninc = 0; m_ndec = 0; m_hinc = 0; m_hdec = 0;
            m_div = 1; m_acc = 0; m_pc = 0; exp_tick = 0;
        end else if (norm_wr || hs_wr || div_wr) begin
            if (norm_wr) begin m_ninc = int'(wr_inc); m_ndec = int'(wr_dec); end
            if (hs_wr)   begin m_hinc = int'(wr_inc); m_hdec = int'(wr_dec); end
            if (div_wr)  m_div = int'(wr_div);
            m_acc = 0; m_pc = 0; exp_tick = 0;
        end else begin
            bit step;
            int inc, modv;
            step = 0;
            exp_tick = 0;
            if (m_div == 0) m_pc = 0;
            else if (m_pc == m_div - 1) begin m_pc = 0; step = 1; end
            else m_pc = m_pc + 1;
            inc = 0; modv = 1;
            if (m_hinc != 0) begin inc = m_hinc; modv = m_hdec + 1; end
            else if (m_ninc != 0) begin inc = m_ninc; modv = m_ndec + 1; end
            if (step && inc != 0) begin
                if (inc >= modv) begin m_acc = 0; exp_tick = 1; end
                else begin
                    m_acc = m_acc + inc;
                    if (m_acc >= modv) begin m_acc = m_acc - modv; exp_tick = 1; end
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n !== 1'bx && !done) begin
            vectors++;
            if (tick !== exp_tick) begin
                miscompares++;
                $display("FAIL %s: tick=%0b expected %0b at %0t", cur_req, tick, exp_tick, $time);
            end
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: count=%0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic write_norm(input int inc, input int dec);
        @(negedge clk);
        norm_wr = 1'b1; wr_inc = INC_W'(inc); wr_dec = DEC_W'(dec);
        @(negedge clk);
        norm_wr = 1'b0;
    endtask

    task automatic write_hs(input int inc, input int dec);
        @(negedge clk);
        hs_wr = 1'b1; wr_inc = INC_W'(inc); wr_dec = DEC_W'(dec);
        @(negedge clk);
        hs_wr = 1'b0;
    endtask

    task automatic write_div(input int d);
        @(negedge clk);
        div_wr = 1'b1; wr_div = PRE_W'(d);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // Count ticks over n cycles; the i-th sample follows the i-th edge after a write.
    task automatic count_ticks(input int n, input string req, input int expected);
        int cnt;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick === 1'b1) cnt++;
        end
        check(req, cnt, expected);
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; norm_wr = 1'b0; hs_wr = 1'b0; div_wr = 1'b0;
        wr_inc = '0; wr_dec = '0; wr_div = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4: reset state, no registers configured.
        cur_req = "R1";
        count_ticks(30, "R1", 0);

        // R8: standard-mode setting, one step per clock.
        cur_req = "R8";
        write_norm(1, 499);
        count_ticks(1000, "R8", 2);
        write_norm(1, 124);
        count_ticks(1250, "R8", 10);

        // R3 / R8: high-speed register takes priority over the normal one.
        cur_req = "R3";
        write_hs(41, 152);
        count_ticks(1530, "R3", 410);
        // R3: clearing the high-speed register falls back to the normal one.
        write_hs(0, 0);
        count_ticks(1250, "R3", 10);

        // R2: fractional ratio 3/10 from a cleared accumulator.
        cur_req = "R2";
        write_norm(3, 9);
        count_ticks(20, "R2", 6);
        count_ticks(7, "R2", 2);

        // R6: prescale of 3 with ratio 1/125 over 1500 clocks.
        cur_req = "R6";
        write_norm(1, 124);
        write_div(3);
        count_ticks(1500, "R6", 4);
        // R6: zero prescale halts stepping.
        write_norm(1, 1);
        write_div(0);
        count_ticks(200, "R6", 0);
        write_div(1);

        // R4: both registers inactive.
        cur_req = "R4";
        write_norm(0, 0);
        count_ticks(100, "R4", 0);

        // R7: increment larger than the modulus ticks every step.
        cur_req = "R7";
        write_norm(200, 50);
        count_ticks(100, "R7", 100);

        // R5: a rewrite mid-period restarts the accumulator.
        cur_req = "R5";
        write_norm(1, 4);
        repeat (3) @(negedge clk);
        write_norm(1, 4);
        count_ticks(4, "R5", 0);
        count_ticks(1, "R5", 1);

        // R1: reset in mid-run clears the configuration.
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        count_ticks(600, "R1", 0);

        finish_run();
    end

endmodule